// File: doc/BRIEF.md
# Circular Queue with Rotating One-Hot Pointers

This block is a first-in first-out queue of fixed depth. The write position and the read position are each held as a one-hot ring that rotates by one place per accepted operation. Each bit of a ring enables one storage word directly, so the block needs no address decoder. A word pushed in is returned by a later pop in the order of arrival.

Empty and full come from comparing the two rings, using the bitwise AND of their bits, together with one lap bit per ring that flips each time that ring passes from the last word back to the first. A pop on an empty queue returns zero and leaves the read ring where it is. A push on a full queue is discarded. Each of these two cases sets its own sticky flag, and only reset clears the flags. Popped data is registered and appears on the cycle after the pop.

Top module: `ring_fifo`

## Requirements
- R1: After reset, `empty_o`=1, `full_o`=0, `underflow_o`=0, `overflow_o`=0 and `pop_data_o`=0.
- R2: A push on a queue that is not full stores `push_data_i` in the word at the write position and moves the write position one place.
- R3: Both positions wrap from word DEPTH-1 to word 0, and the queue keeps arrival order across any number of wraps.
- R4: A pop on a non-empty queue makes `pop_data_o` equal to the oldest stored word on the next cycle, and moves the read position one place.
- R5: A pop on an empty queue makes `pop_data_o` equal to 0 on the next cycle and sets `underflow_o`, which stays at 1 until reset. The read position does not move.
- R6: `full_o` is 1 exactly when DEPTH words are held. `empty_o` is 1 exactly when no words are held. The two are never 1 together.
- R7: A push on a full queue is discarded and sets `overflow_o`, which stays at 1 until reset. The stored contents are unchanged.
- R8: A push and a pop in the same cycle on a queue that is neither empty nor full both take effect, and the occupancy stays the same.
- R9: A push and a pop in the same cycle on an empty queue store the pushed word and report an underflow. The same pair on a full queue returns the oldest word and reports an overflow.
- R10: When `pop_i` is 0, `pop_data_o` keeps its value.
- R11: Each position ring has exactly one bit set on every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Request to append `push_data_i` |
| push_data_i | input | WIDTH | Word to append |
| pop_i | input | 1 | Request to remove the oldest word |
| pop_data_o | output | WIDTH | Registered result of the last pop |
| empty_o | output | 1 | No words held |
| full_o | output | 1 | DEPTH words held |
| underflow_o | output | 1 | Sticky: a pop arrived while empty |
| overflow_o | output | 1 | Sticky: a push arrived while full |

## Verification
The assertions run on every cycle. They check that each ring holds a single set bit, that empty and full are never 1 together, that both error flags stay set once raised, and that a refused pop returns zero and leaves the read ring in place. They also check that an accepted pop registers the word the store presented and that a refused push raises the overflow flag. Data ordering across wraps, the exact occupancy at which full appears, and the mixed cases of simultaneous push and pop at the empty and full limits can only be shown by the bench. The bench compares the block against a behavioural queue model on every clock.

// File: rtl/ring_fifo_pkg.sv
package ring_fifo_pkg;
    localparam int unsigned DEF_DEPTH = 8;
    localparam int unsigned DEF_WIDTH = 8;

    typedef struct packed {
        logic empty;
        logic full;
    } ring_level_t;
endpackage

// File: rtl/ring_ptr.sv
module ring_ptr #(
    parameter int unsigned DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    output logic [DEPTH-1:0] oh_o,
    output logic             lap_o
);
    localparam logic [DEPTH-1:0] HOME = DEPTH'(1);

    typedef struct packed {
        logic [DEPTH-1:0] oh;
        logic             lap;
    } ptr_t;

    ptr_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (adv_i) begin
            s_d.oh = {s_q.oh[DEPTH-2:0], s_q.oh[DEPTH-1]};
            if (s_q.oh[DEPTH-1]) begin
                s_d.lap = ~s_q.lap;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.oh  <= HOME;
            s_q.lap <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign oh_o  = s_q.oh;
    assign lap_o = s_q.lap;
endmodule

// File: rtl/ring_store.sv
module ring_store #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             wr_en_i,
    input  logic [DEPTH-1:0] wr_sel_i,
    input  logic [WIDTH-1:0] wr_data_i,
    input  logic [DEPTH-1:0] rd_sel_i,
    output logic [WIDTH-1:0] rd_data_o
);
    logic [WIDTH-1:0] word_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (wr_en_i && wr_sel_i[g]) begin
                word_q[g] <= wr_data_i;
            end
        end
    end

    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_sel_i[i]) begin
                rd_data_o = rd_data_o | word_q[i];
            end
        end
    end
endmodule

// File: rtl/ring_fifo.sv
module ring_fifo
    import ring_fifo_pkg::*;
#(
    parameter int unsigned DEPTH = DEF_DEPTH,
    parameter int unsigned WIDTH = DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [WIDTH-1:0] push_data_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] pop_data_o,
    output logic             empty_o,
    output logic             full_o,
    output logic             underflow_o,
    output logic             overflow_o
);
    typedef struct packed {
        logic [WIDTH-1:0] dout;
        logic             uflow;
        logic             oflow;
    } ctl_t;

    ctl_t        c_d, c_q;
    ring_level_t lvl;

    logic [DEPTH-1:0] wr_oh, rd_oh;
    logic             wr_lap, rd_lap;
    logic             same_slot;
    logic             push_ok, pop_ok;
    logic [WIDTH-1:0] rd_word;

    // Positions coincide when the rings share their set bit.
    assign same_slot = |(wr_oh & rd_oh);
    assign lvl.empty = same_slot && (wr_lap == rd_lap);
    assign lvl.full  = same_slot && (wr_lap != rd_lap);

    assign push_ok = push_i && !lvl.full;
    assign pop_ok  = pop_i && !lvl.empty;

    ring_ptr #(.DEPTH(DEPTH)) u_wr_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv_i (push_ok),
        .oh_o  (wr_oh),
        .lap_o (wr_lap)
    );

    ring_ptr #(.DEPTH(DEPTH)) u_rd_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv_i (pop_ok),
        .oh_o  (rd_oh),
        .lap_o (rd_lap)
    );

    ring_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk       (clk),
        .wr_en_i   (push_ok),
        .wr_sel_i  (wr_oh),
        .wr_data_i (push_data_i),
        .rd_sel_i  (rd_oh),
        .rd_data_o (rd_word)
    );

    always_comb begin
        c_d = c_q;
        if (pop_i) begin
            c_d.dout = pop_ok ? rd_word : '0;
        end
        if (pop_i && lvl.empty) begin
            c_d.uflow = 1'b1;
        end
        if (push_i && lvl.full) begin
            c_d.oflow = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign pop_data_o  = c_q.dout;
    assign underflow_o = c_q.uflow;
    assign overflow_o  = c_q.oflow;
    assign empty_o     = lvl.empty;
    assign full_o      = lvl.full;
endmodule

// File: rtl/ring_fifo_chk.sv
module ring_fifo_chk #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_i,
    input logic             pop_i,
    input logic [WIDTH-1:0] pop_data_o,
    input logic             empty_o,
    input logic             full_o,
    input logic             underflow_o,
    input logic             overflow_o,
    input logic [DEPTH-1:0] wr_oh,
    input logic [DEPTH-1:0] rd_oh,
    input logic [WIDTH-1:0] rd_word
);
    // R11
    wr_ring_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wr_oh) == 1);

    // R11
    rd_ring_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rd_oh) == 1);

    // R6
    level_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty_o && full_o));

    // R5
    underflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_o |=> underflow_o);

    // R7
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> overflow_o);

    // R5
    empty_pop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && empty_o) |=> (pop_data_o == '0) && underflow_o && $stable(rd_oh));

    // R4
    pop_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !empty_o) |=> pop_data_o == $past(rd_word));

    // R7
    full_push_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o) |=> overflow_o && $stable(wr_oh));

    // R10
    hold_dout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_i |=> $stable(pop_data_o));
endmodule

bind ring_fifo ring_fifo_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .pop_data_o  (pop_data_o),
    .empty_o     (empty_o),
    .full_o      (full_o),
    .underflow_o (underflow_o),
    .overflow_o  (overflow_o),
    .wr_oh       (wr_oh),
    .rd_oh       (rd_oh),
    .rd_word     (rd_word)
);

// File: tb/ring_fifo_tb_top.sv
module ring_fifo_tb_top;
    localparam int DEPTH = 8;
    localparam int WIDTH = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             push_i = 1'b0;
    logic [WIDTH-1:0] push_data_i = '0;
    logic             pop_i = 1'b0;
    logic [WIDTH-1:0] pop_data_o;
    logic             empty_o, full_o, underflow_o, overflow_o;

    int n_vec = 0;
    int n_bad = 0;

    logic [WIDTH-1:0] mq[$];
    logic [WIDTH-1:0] m_dout = '0;
    logic             m_uf = 1'b0;
    logic             m_of = 1'b0;

    always #5 clk = ~clk;

    ring_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push_i),
        .push_data_i (push_data_i),
        .pop_i       (pop_i),
        .pop_data_o  (pop_data_o),
        .empty_o     (empty_o),
        .full_o      (full_o),
        .underflow_o (underflow_o),
        .overflow_o  (overflow_o)
    );

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FIAL-free %s", "");
        end
    endtask

    task automatic check_all(input string tag);
        n_vec++;
        if (pop_data_o !== m_dout || empty_o !== (mq.size() == 0) ||
            full_o !== (mq.size() == DEPTH) || underflow_o !== m_uf || overflow_o !== m_of) begin
            n_bad++;
            $display("FAIL %s: act dout=%0h e=%0b f=%0b uf=%0b of=%0b exp dout=%0h e=%0b f=%0b uf=%0b of=%0b",
                     tag, pop_data_o, empty_o, full_o, underflow_o, overflow_o,
                     m_dout, mq.size() == 0, mq.size() == DEPTH, m_uf, m_of);
        end
    endtask

    // Drive at the falling edge, update the model, check after the next rising edge.
    task automatic step(input logic ps, input logic [WIDTH-1:0] d, input logic pp, input string tag);
        bit was_empty, was_full;
        push_i      = ps;
        push_data_i = d;
        pop_i       = pp;
        was_empty = (mq.size() == 0);
        was_full  = (mq.size() == DEPTH);
        if (pp) begin
            if (was_empty) begin
                m_dout = '0;
                m_uf   = 1'b1;
            end else begin
                m_dout = mq.pop_front();
            end
        end
        if (ps) begin
            if (was_full) m_of = 1'b1;
            else mq.push_back(d);
        end
        @(posedge clk);
        @(negedge clk);
        push_i = 1'b0;
        pop_i  = 1'b0;
        check_all(tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        mq.delete();
        m_dout = '0;
        m_uf = 1'b0;
        m_of = 1'b0;
        @(negedge clk);
        check_all("R1 reset state");
    endtask

    initial begin
        fork
            begin
                @(negedge clk);
                do_reset();

                // R2 R6: fill to full with distinct words
                for (int i = 0; i < DEPTH; i++) step(1'b1, 8'h10 + 8'(i), 1'b0, "R2 R6 fill");
                // R7: push while full is discarded
                step(1'b1, 8'hEE, 1'b0, "R7 push on full");
                step(1'b0, 8'h00, 1'b0, "R10 idle hold");
                // R4: drain in order
                for (int i = 0; i < DEPTH; i++) step(1'b0, 8'h00, 1'b1, "R4 drain");
                // R5: pop while empty, then prove read position did not move
                step(1'b0, 8'h00, 1'b1, "R5 pop on empty");
                step(1'b1, 8'h5A, 1'b0, "R5 push after underflow");
                step(1'b0, 8'h00, 1'b1, "R5 word after underflow");
                step(1'b0, 8'h00, 1'b0, "R10 hold after pop");

                do_reset();
                // R3 R8: many wraps with mixed traffic
                step(1'b1, 8'hA0, 1'b0, "R3 prime");
                step(1'b1, 8'hA1, 1'b0, "R3 prime");
                for (int i = 0; i < 5 * DEPTH; i++) step(1'b1, 8'(i * 7 + 3), 1'b1, "R8 R3 push+pop");
                // R9: push+pop on empty
                step(1'b0, 8'h00, 1'b1, "R3 drain");
                step(1'b0, 8'h00, 1'b1, "R3 drain");
                step(1'b1, 8'hC3, 1'b1, "R9 push+pop on empty");
                step(1'b0, 8'h00, 1'b1, "R9 stored word");
                // R9: push+pop on full
                do_reset();
                for (int i = 0; i < DEPTH; i++) step(1'b1, 8'h80 + 8'(i), 1'b0, "R6 fill");
                step(1'b1, 8'h77, 1'b1, "R9 push+pop on full");
                for (int i = 0; i < DEPTH; i++) step(1'b0, 8'h00, 1'b1, "R9 R7 drain after full");

                // R2 R3 R5 R7 R8: random traffic
                do_reset();
                for (int i = 0; i < 2000; i++)
                    step(1'($urandom), 8'($urandom), 1'($urandom), "R2 R3 R8 random");
            end
            begin
                repeat (100000) @(posedge clk);
                n_vec++;
                n_bad++;
                $display("FAIL watchdog: act=running exp=done");
            end
        join_any
        disable fork;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule